// File: doc/BRIEF.md
# Walsh-Series Waveform Replay Core

The core accepts a frame of N signed samples and, as each one arrives, folds it into N Walsh coefficients. Each coefficient register adds the sample or its two's-complement negative, according to one Walsh sign. No subtractor is used. The 1/N factor of the forward transform is left out at this stage, so the coefficients are kept unscaled at width WO = WI + log2(N).

A second Walsh index runs freely on the clock. On every cycle each coefficient is passed through with or without negation, according to the sign for the current replay index. The N terms are summed by a serial adder chain at width WO. The log2(N) low bits of the sum are dropped, which applies the 1/N scale, so the stored waveform comes back at the input width, one sample per clock, repeating with period N.

Samples enter through a valid/ready stream input. The core never applies back-pressure: ready is low only during reset and stays high afterwards. The output has no back-pressure either. A plain `pass` enable gates whether the replayed sample is presented, and the output valid flag follows that enable once the pipeline has filled.

Top module: `walsh_wave_core`

## Requirements
- R1: While `rst` is high, `s_ready`, `o_valid` and `o_data` are 0. After reset, with no sample accepted, `o_data` reads 0 at every replay index.
- R2: `s_ready` is 0 while `rst` is high and is 1 from the first clock edge after release. A sample is taken on a rising edge where `s_valid` and `s_ready` are both 1. Idle cycles between samples are allowed and are ignored.
- R3: Accepted samples are numbered k = 0, 1, 2, … modulo N from reset. Sample k enters coefficient n negated when the parity of (n AND k) is odd, and unnegated otherwise. Replay index t applies the same rule with t in place of k. This is natural Hadamard ordering.
- R4: On the j-th rising edge after reset release (j ≥ 2), `o_data` takes the reconstructed sample for position (j−2) mod N. A sample accepted at edge E is reflected from edge E+3 onwards. Replay repeats with period N.
- R5: Every WI-bit input value, including −2^(WI−1) and 2^(WI−1)−1, is reproduced exactly.
- R6: While `pass` is 0, `o_data` and `o_valid` are 0 in the same cycle. `pass` does not disturb the replay index.
- R7: `o_valid` is 1 exactly when `pass` is 1 and at least two rising edges have passed since reset release.
- R8: Samples beyond N keep accumulating. Position t reads the low WI bits of the sum of all samples entered at positions congruent to t modulo N.
- R9: In a partly loaded frame, positions that have received no sample read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for capture and replay |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample present |
| s_ready | output | 1 | Core can take a sample (1 whenever not in reset) |
| s_data | input | WI | Signed input sample |
| pass | input | 1 | Output enable |
| o_valid | output | 1 | Replayed sample presented |
| o_data | output | WI | Signed replayed sample, 0 when not presented |

## Verification
The assertions take for granted that `rst` is held for at least one clock edge, so the index counters start from zero. They also assume `pass` only changes between edges. The bench drives every input at the falling edge and releases reset there. It counts rising edges from release to predict the replay index, and waits three edges after the last accepted sample before comparing. Random gaps in `s_valid` exercise the stream rule without ever relying on back-pressure.

// File: rtl/walsh_wave_pkg.sv
package walsh_wave_pkg;
  // Walsh sign in natural (Hadamard) order: 1 means negate.
  function automatic logic walsh_bit(input logic [15:0] n, input logic [15:0] k);
    return ^(n & k);
  endfunction
endpackage

// File: rtl/walsh_wave_seq.sv
module walsh_wave_seq #(
  parameter int LOGN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic [LOGN-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= idx + LOGN'(1);
  end
endmodule

// File: rtl/walsh_wave_negsel.sv
module walsh_wave_negsel #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] a,
  input  logic                neg,
  output logic signed [W-1:0] y
);
  logic signed [W-1:0] inv;
  logic signed [W-1:0] twos;
  assign inv  = ~a;
  assign twos = inv + W'(1);
  assign y    = neg ? twos : a;
endmodule

// File: rtl/walsh_wave_lane.sv
module walsh_wave_lane
  import walsh_wave_pkg::*;
#(
  parameter int WI   = 8,
  parameter int LOGN = 3,
  parameter int IDX  = 0,
  localparam int WO  = WI + LOGN
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic signed [WI-1:0] x,
  input  logic [LOGN-1:0]      enter_idx,
  input  logic [LOGN-1:0]      play_idx,
  output logic signed [WO-1:0] g
);
  logic signed [WO-1:0] x_ext, f_d, f_q, acc, g_d;
  logic                 f_vld;
  logic                 s_in, s_out;

  assign x_ext = {{LOGN{x[WI-1]}}, x};
  assign s_in  = walsh_bit(16'(IDX), 16'(enter_idx));
  assign s_out = walsh_bit(16'(IDX), 16'(play_idx));

  walsh_wave_negsel #(.W(WO)) u_sel_in  (.a(x_ext), .neg(s_in),  .y(f_d));
  walsh_wave_negsel #(.W(WO)) u_sel_out (.a(acc),   .neg(s_out), .y(g_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q   <= '0;
      f_vld <= 1'b0;
      acc   <= '0;
      g     <= '0;
    end else begin
      f_vld <= take;
      if (take)  f_q <= f_d;
      if (f_vld) acc <= acc + f_q;
      g <= g_d;
    end
  end
endmodule

// File: rtl/walsh_wave_core.sv
module walsh_wave_core #(
  parameter int WI   = 8,
  parameter int N    = 8,
  localparam int LOGN = $clog2(N),
  localparam int WO   = WI + LOGN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [WI-1:0] s_data,
  input  logic          pass,
  output logic          o_valid,
  output logic [WI-1:0] o_data
);
  logic                 take;
  logic [LOGN-1:0]      enter_idx, play_idx;
  logic signed [WO-1:0] g    [N];
  logic signed [WO-1:0] part [N];
  logic signed [WI-1:0] h_q;
  logic [1:0]           fill_q;

  assign take = s_valid & s_ready;

  walsh_wave_seq #(.LOGN(LOGN)) u_enter_seq (.clk(clk), .rst(rst), .adv(take), .idx(enter_idx));
  walsh_wave_seq #(.LOGN(LOGN)) u_play_seq  (.clk(clk), .rst(rst), .adv(1'b1), .idx(play_idx));

  for (genvar n = 0; n < N; n++) begin : g_lane
    walsh_wave_lane #(.WI(WI), .LOGN(LOGN), .IDX(n)) u_lane (
      .clk(clk), .rst(rst), .take(take), .x(s_data),
      .enter_idx(enter_idx), .play_idx(play_idx), .g(g[n])
    );
  end

  // serial reconstruction chain, width WO, wraps modulo 2^WO
  assign part[0] = g[0];
  for (genvar n = 1; n < N; n++) begin : g_chain
    assign part[n] = part[n-1] + g[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ready <= 1'b0;
      h_q     <= '0;
      fill_q  <= '0;
    end else begin
      s_ready <= 1'b1;
      h_q     <= part[N-1][WO-1:LOGN];
      fill_q  <= {fill_q[0], 1'b1};
    end
  end

  assign o_valid = pass & fill_q[1];
  assign o_data  = pass ? h_q : '0;
endmodule

// File: rtl/walsh_wave_core_chk.sv
module walsh_wave_core_chk #(
  parameter int WI   = 8,
  parameter int LOGN = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            s_valid,
  input logic            s_ready,
  input logic            pass,
  input logic            o_valid,
  input logic [WI-1:0]   o_data,
  input logic [LOGN-1:0] enter_idx,
  input logic [LOGN-1:0] play_idx
);
  p_ready_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> s_ready);

  p_enter_step_r3: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (enter_idx - $past(enter_idx)) == LOGN'(1));

  p_enter_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> $stable(enter_idx));

  p_play_step_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (play_idx - $past(play_idx)) == LOGN'(1));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !pass |-> (o_data == '0 && !o_valid));

  p_valid_needs_pass_r7: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> pass);
endmodule

bind walsh_wave_core walsh_wave_core_chk #(.WI(WI), .LOGN(LOGN)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .pass(pass),
  .o_valid(o_valid), .o_data(o_data), .enter_idx(enter_idx), .play_idx(play_idx)
);

// File: tb/test_walsh_wave_core.sv
`timescale 1ns/1ps
module test_walsh_wave_core;
  localparam int WI   = 8;
  localparam int N    = 8;
  localparam int LOGN = 3;

  logic          clk = 0;
  logic          rst = 1;
  logic          s_valid = 0;
  logic          s_ready;
  logic [WI-1:0] s_data = '0;
  logic          pass = 0;
  logic          o_valid;
  logic [WI-1:0] o_data;

  int checks = 0, fails = 0, cyc = 0, pos = 0;
  int acc_pos [N];
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  walsh_wave_core #(.WI(WI), .N(N)) i_walsh_wave_core (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .pass(pass), .o_valid(o_valid), .o_data(o_data)
  );

  function automatic int wsgn(int n, int k);
    return ($countones(n & k) % 2) ? -1 : 1;
  endfunction

  // forward then inverse Walsh series over all samples entered so far
  function automatic logic [WI-1:0] ref_out(int t);
    int total = 0;
    for (int n = 0; n < N; n++) begin
      int coef = 0;
      for (int k = 0; k < N; k++) coef += wsgn(n, k) * acc_pos[k];
      total += wsgn(n, t) * coef;
    end
    return WI'(total >>> LOGN);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; s_valid = 0; pos = 0;
    for (int k = 0; k < N; k++) acc_pos[k] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic send(input logic [WI-1:0] x);
    bit acc;
    s_valid = 1; s_data = x;
    acc = s_ready;
    @(posedge clk);
    if (acc) begin
      acc_pos[pos] += int'($signed(x));
      pos = (pos + 1) % N;
    end
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic play(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      int t;
      logic [WI-1:0] e;
      @(negedge clk);
      t = (cyc - 2) % N;
      e = pass ? ref_out(t) : '0;
      check(tag, int'($signed(o_data)), int'($signed(e)));
      check("R7 valid", int'(o_valid), int'(pass && cyc >= 2));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R1 / R2: reset state
    repeat (2) @(negedge clk);
    check("R1 ready in reset (R2)", int'(s_ready), 0);
    check("R1 valid in reset", int'(o_valid), 0);
    check("R1 data in reset", int'(o_data), 0);
    do_reset();
    pass = 1;
    play(2 * N, "R1 empty frame");
    check("R2 ready after release", int'(s_ready), 1);

    // R3 / R4: random full frames, back to back
    for (int f = 0; f < 3; f++) begin
      do_reset();
      for (int k = 0; k < N; k++) send(WI'($urandom));
      settle();
      play(2 * N, "R3 R4 random frame");
    end

    // R5: extreme values
    do_reset();
    for (int k = 0; k < N; k++) send((k % 2) ? 8'h7f : 8'h80);
    settle();
    play(2 * N, "R5 alternating extremes");
    do_reset();
    for (int k = 0; k < N; k++) send(8'h80);
    settle();
    play(N, "R5 all most-negative");

    // R6: pass low, then back on with unchanged phase
    @(negedge clk) pass = 0;
    play(5, "R6 pass low");
    pass = 1;
    play(N + 3, "R6 phase after pass");

    // R8: more than N samples accumulate per position
    for (int k = 0; k < N; k++) send(WI'($urandom));
    settle();
    play(2 * N, "R8 second frame summed");

    // R9: partial frame
    do_reset();
    for (int k = 0; k < 3; k++) send(WI'($urandom));
    settle();
    play(2 * N, "R9 partial frame");

    // R2: random idle gaps between samples
    do_reset();
    for (int k = 0; k < N; k++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      send(WI'($urandom));
    end
    settle();
    play(2 * N, "R2 gaps in valid");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule